// File: doc/BRIEF.md
# Burst SRAM Address and Command Front End

This block is the synchronous control stage in front of a flow-through burst SRAM whose word is split into byte lanes. On every rising clock edge it looks at two address strobes, an advance input, three chip enables and the write enables. From these it decides whether the edge starts a new access, continues or suspends a burst, or deselects the device. Its registered outputs are the word address for the array, one write strobe per byte lane and an enable that allows the data outputs to be driven.

The two strobes follow different rules. The processor-side strobe is gated by the main chip enable, wins over the other strobe and always starts a read. The controller-side strobe is not gated by the main enable, needs the processor strobe to be high, and samples the write enables on its own edge. Bursts are four beats long and wrap inside a four-word block. The low two address bits advance in XOR-interleaved order or in linear-add order. The order is picked by a static select input that is captured during reset.

Top module: `bsram_front`

## Requirements
- R1: While reset is applied and on the first edge after it, `word_addr` is 0, `wr_strb` is 0 and `drive_en` is 0.
- R2: An edge with `pstrb_n`=0, `ce_main_n`=0, `ce_hi`=1 and `ce_lo_n`=0 loads `addr_in` into `word_addr` and starts a read (`wr_strb`=0, `drive_en`=1). The write enables, `cstrb_n` and `adv_n` have no effect on that edge.
- R3: With `ce_main_n`=1, `pstrb_n`=0 has no effect. If `cstrb_n` is also 1, the edge holds the current address and does not advance it.
- R4: A controller start needs `cstrb_n`=0 and `pstrb_n`=1. With all three enables active, it loads `addr_in` and samples the write enables on that same edge. With `ce_main_n`=1 it deselects. If both strobes are low, the processor start of R2 takes priority.
- R5: While an access is active and both strobes are high, `adv_n`=0 moves the burst to its next beat and `adv_n`=1 holds the current address. Bits above the low two never change.
- R6: With the order select captured as 1, beat k (0..3, modulo 4) has low bits = start XOR k.
- R7: With the order select captured as 0, beat k has low bits = (start + k) mod 4.
- R8: Write decode: `gwr_n`=0 sets every bit of `wr_strb`. With `gwr_n`=1 and `bwen_n`=0, `wr_strb[i]` = NOT `bw_n[i]`, where bit 0 is the low byte lane. Otherwise `wr_strb` is 0 and the cycle is a read.
- R9: `drive_en` is 1 on an active read cycle and 0 whenever any `wr_strb` bit is set.
- R10: A taken strobe with `ce_hi`=0 or `ce_lo_n`=1 deselects: `drive_en`=0 and `wr_strb`=0. Later continue edges write nothing and drive nothing until a new access starts.
- R11: The order select is sampled only while reset is applied. Changing it afterwards has no effect on the burst order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pstrb_n | input | 1 | Processor-side address strobe, active low |
| cstrb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_main_n | input | 1 | Main chip enable, active low |
| ce_hi | input | 1 | Secondary chip enable, active high |
| ce_lo_n | input | 1 | Secondary chip enable, active low |
| gwr_n | input | 1 | Write-all-lanes enable, active low |
| bwen_n | input | 1 | Per-lane write enable qualifier, active low |
| bw_n | input | NLANE | Per-lane write selects, active low |
| order_sel | input | 1 | Burst order: 1 interleaved, 0 linear; captured in reset |
| addr_in | input | AW | External word address |
| word_addr | output | AW | Registered word address to the array |
| wr_strb | output | NLANE | Registered per-lane write strobes |
| drive_en | output | 1 | Registered permission to drive read data |

## Verification
The bench builds the block with its defaults: a 21-bit address and two byte lanes. With two lanes, all sixteen combinations of the write-all, lane-qualifier and lane-select inputs can be swept on controller starts. All four start offsets are walked through a full wrapping burst in both orders, using two reset phases, one per captured order value. The strobe priority, the main-enable gating and each deselect condition are hit explicitly. The second reset also flips the order select after reset to show that the change has no effect.

// File: rtl/bsram_front_pkg.sv
// Package: shared command encoding and burst-order arithmetic for the
// burst SRAM front end. Assumes a fixed four-beat burst (two low bits).
package bsram_front_pkg;

    localparam int BURST_W = 2;

    typedef enum logic [2:0] {
        CMD_CONT     = 3'd0,  // no strobe taken, hold address
        CMD_ADV      = 3'd1,  // no strobe taken, step the burst
        CMD_LOAD_RD  = 3'd2,  // processor start, always a read
        CMD_LOAD_CTL = 3'd3,  // controller start, writes sampled
        CMD_DESEL    = 3'd4   // strobe taken while not selected
    } cmd_e;

    // Low address bits for beat 'cnt' of a burst starting at 'start'.
    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] cnt,
        input logic               interleave
    );
        logic [BURST_W-1:0] r;
        if (interleave) r = start ^ cnt;
        else            r = start + cnt;
        return r;
    endfunction

endpackage

// File: rtl/bsram_cmd_decode.sv
// Module: bsram_cmd_decode
// Classifies one clock edge from the strobes, advance and chip enables.
// Assumes all inputs are already synchronous to the clock; purely
// combinational, its result is registered by the caller.
module bsram_cmd_decode
    import bsram_front_pkg::*;
(
    input  logic pstrb_n,
    input  logic cstrb_n,
    input  logic adv_n,
    input  logic ce_main_n,
    input  logic ce_hi,
    input  logic ce_lo_n,
    input  logic active,
    output cmd_e cmd
);

    logic p_take;
    logic c_take;
    logic sec_ok;

    // Strobe qualification: main enable gates only the processor strobe.
    always_comb begin
        p_take = !pstrb_n && !ce_main_n;
        c_take = !cstrb_n && pstrb_n;
        sec_ok = ce_hi && !ce_lo_n;
    end

    // Priority choice: processor strobe, controller strobe, then burst.
    always_comb begin
        if (p_take)
            cmd = sec_ok ? CMD_LOAD_RD : CMD_DESEL;
        else if (c_take)
            cmd = (sec_ok && !ce_main_n) ? CMD_LOAD_CTL : CMD_DESEL;
        else if (pstrb_n && cstrb_n && !adv_n && active)
            cmd = CMD_ADV;
        else
            cmd = CMD_CONT;
    end

endmodule

// File: rtl/bsram_wr_decode.sv
// Module: bsram_wr_decode
// Turns write-all, lane qualifier and lane selects into a lane mask.
// Assumes active-low inputs; combinational.
module bsram_wr_decode #(
    parameter int NLANE = 2
) (
    input  logic             gwr_n,
    input  logic             bwen_n,
    input  logic [NLANE-1:0] bw_n,
    output logic [NLANE-1:0] mask
);

    // Lane mask: write-all dominates, then qualified per-lane selects.
    always_comb begin
        if (!gwr_n)       mask = '1;
        else if (!bwen_n) mask = ~bw_n;
        else              mask = '0;
    end

endmodule

// File: rtl/bsram_burst_addr.sv
// Module: bsram_burst_addr
// Holds the loaded word address and a wrapping beat counter and forms
// the current word address in interleaved or linear order. Assumes the
// order select is static; it is captured only during reset.
module bsram_burst_addr
    import bsram_front_pkg::*;
#(
    parameter int AW = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          order_sel,
    input  cmd_e          cmd,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] word_addr
);

    localparam int HI_W = AW - BURST_W;

    logic [HI_W-1:0]    base_hi;
    logic [BURST_W-1:0] start_lo;
    logic [BURST_W-1:0] cnt;
    logic               order_q;
    logic               past_ok;

    // Address state: load on a start, step on advance, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hi  <= '0;
            start_lo <= '0;
            cnt      <= '0;
            order_q  <= order_sel;
        end else begin
            case (cmd)
                CMD_LOAD_RD, CMD_LOAD_CTL: begin
                    base_hi  <= addr_in[AW-1:BURST_W];
                    start_lo <= addr_in[BURST_W-1:0];
                    cnt      <= '0;
                end
                CMD_ADV: cnt <= cnt + 1'b1;
                default: ;
            endcase
        end
    end

    // Marks that at least one edge has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // Output address: upper bits plus ordered low bits.
    always_comb begin
        word_addr = {base_hi, burst_low(start_lo, cnt, order_q)};
    end

    // R5: a hold edge leaves the whole address unchanged.
    assert_hold_keeps_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(cmd == CMD_CONT) |-> $stable(word_addr));

    // R5: an advance never touches the bits above the burst field.
    assert_adv_keeps_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(cmd == CMD_ADV) |-> $stable(word_addr[AW-1:BURST_W]));

    // R11: the captured order does not change outside reset.
    assert_order_static_R11: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> $stable(order_q));

endmodule

// File: rtl/bsram_front.sv
// Module: bsram_front (top)
// Synchronous command front end of a flow-through burst SRAM. Decodes
// each edge, keeps the burst address and registers the lane write
// strobes and the output-drive permission. Assumes synchronous inputs,
// a static order select and a synchronous active-low reset.
module bsram_front
    import bsram_front_pkg::*;
#(
    parameter int AW    = 21,
    parameter int NLANE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pstrb_n,
    input  logic             cstrb_n,
    input  logic             adv_n,
    input  logic             ce_main_n,
    input  logic             ce_hi,
    input  logic             ce_lo_n,
    input  logic             gwr_n,
    input  logic             bwen_n,
    input  logic [NLANE-1:0] bw_n,
    input  logic             order_sel,
    input  logic [AW-1:0]    addr_in,
    output logic [AW-1:0]    word_addr,
    output logic [NLANE-1:0] wr_strb,
    output logic             drive_en
);

    cmd_e             cmd;
    logic             active;
    logic [NLANE-1:0] lane_mask;
    logic             past_ok;

    bsram_cmd_decode u_dec (
        .pstrb_n   (pstrb_n),
        .cstrb_n   (cstrb_n),
        .adv_n     (adv_n),
        .ce_main_n (ce_main_n),
        .ce_hi     (ce_hi),
        .ce_lo_n   (ce_lo_n),
        .active    (active),
        .cmd       (cmd)
    );

    bsram_wr_decode #(.NLANE(NLANE)) u_wr (
        .gwr_n  (gwr_n),
        .bwen_n (bwen_n),
        .bw_n   (bw_n),
        .mask   (lane_mask)
    );

    bsram_burst_addr #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .order_sel (order_sel),
        .cmd       (cmd),
        .addr_in   (addr_in),
        .word_addr (word_addr)
    );

    // Cycle state: selection, lane strobes and drive permission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            wr_strb  <= '0;
            drive_en <= 1'b0;
        end else begin
            case (cmd)
                CMD_LOAD_RD: begin
                    active   <= 1'b1;
                    wr_strb  <= '0;
                    drive_en <= 1'b1;
                end
                CMD_LOAD_CTL: begin
                    active   <= 1'b1;
                    wr_strb  <= lane_mask;
                    drive_en <= (lane_mask == '0);
                end
                CMD_DESEL: begin
                    active   <= 1'b0;
                    wr_strb  <= '0;
                    drive_en <= 1'b0;
                end
                default: begin
                    wr_strb  <= active ? lane_mask : '0;
                    drive_en <= active && (lane_mask == '0);
                end
            endcase
        end
    end

    // Marks that at least one edge has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R9: a write cycle never drives the outputs.
    assert_write_blocks_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strb != '0) |-> !drive_en);

    // R2: a processor start ignores the write inputs and reads.
    assert_pstart_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(cmd == CMD_LOAD_RD) |-> (wr_strb == '0) && drive_en);

    // R10: a deselect stops both writing and driving.
    assert_desel_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(cmd == CMD_DESEL) |-> (wr_strb == '0) && !drive_en);

    // R4: the main enable blocks a processor strobe from loading.
    assert_main_gates_pstrb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ce_main_n |-> cmd != CMD_LOAD_RD);

endmodule

// File: tb/bsram_front_tb.sv
// Bench for bsram_front: sweeps start offsets, both orders and all
// write-enable combinations, with expectations computed arithmetically.
module bsram_front_tb;

    localparam int AW    = 21;
    localparam int NLANE = 2;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             pstrb_n, cstrb_n, adv_n;
    logic             ce_main_n, ce_hi, ce_lo_n;
    logic             gwr_n, bwen_n;
    logic [NLANE-1:0] bw_n;
    logic             order_sel;
    logic [AW-1:0]    addr_in;
    logic [AW-1:0]    word_addr;
    logic [NLANE-1:0] wr_strb;
    logic             drive_en;

    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    bsram_front #(.AW(AW), .NLANE(NLANE)) u_dut (
        .clk(clk), .rst_n(rst_n), .pstrb_n(pstrb_n), .cstrb_n(cstrb_n),
        .adv_n(adv_n), .ce_main_n(ce_main_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
        .gwr_n(gwr_n), .bwen_n(bwen_n), .bw_n(bw_n), .order_sel(order_sel),
        .addr_in(addr_in), .word_addr(word_addr), .wr_strb(wr_strb),
        .drive_en(drive_en)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Quiet inputs: no strobe, no advance, no write, selected.
    task automatic quiet();
        pstrb_n = 1'b1; cstrb_n = 1'b1; adv_n = 1'b1;
        ce_main_n = 1'b0; ce_hi = 1'b1; ce_lo_n = 1'b0;
        gwr_n = 1'b1; bwen_n = 1'b1; bw_n = '1;
    endtask

    task automatic do_reset(input logic ord);
        quiet();
        addr_in = '0;
        order_sel = ord;
        rst_n = 1'b0;
        tick();
        chk("R1 reset addr", 32'(word_addr), 32'd0);
        chk("R1 reset wr", 32'(wr_strb), 32'd0);
        chk("R1 reset drive", 32'(drive_en), 32'd0);
        rst_n = 1'b1;
        tick();
        chk("R1 first edge addr", 32'(word_addr), 32'd0);
        chk("R1 first edge drive", 32'(drive_en), 32'd0);
    endtask

    // Full wrapping burst from each start offset in the given order.
    task automatic burst_sweep(input logic ilv, input logic [18:0] hi);
        for (int s = 0; s < 4; s++) begin
            quiet();
            pstrb_n = 1'b0; cstrb_n = 1'b0; adv_n = 1'b0;
            gwr_n = 1'b0; bwen_n = 1'b0; bw_n = '0;
            addr_in = {hi, 2'(s)};
            tick();
            chk("R2 pstart addr", 32'(word_addr), 32'({hi, 2'(s)}));
            chk("R2 pstart wr ignored", 32'(wr_strb), 32'd0);
            chk("R2 pstart drive", 32'(drive_en), 32'd1);
            quiet();
            adv_n = 1'b0;
            addr_in = ~addr_in;
            for (int k = 1; k <= 4; k++) begin
                logic [1:0] e;
                tick();
                e = ilv ? (2'(s) ^ 2'(k)) : (2'(s) + 2'(k));
                chk(ilv ? "R6 interleaved beat" : "R7 linear beat",
                    32'(word_addr), 32'({hi, e}));
                chk("R9 read drive", 32'(drive_en), 32'd1);
            end
            adv_n = 1'b1;
            tick();
            chk("R5 suspend holds", 32'(word_addr), 32'({hi, 2'(s)}));
        end
    endtask

    logic [18:0] hi_a;
    logic [1:0]  exp_m;

    initial begin
        hi_a = 19'h2A5A5;
        do_reset(1'b1);
        burst_sweep(1'b1, hi_a);

        // R3: main enable off, processor strobe ignored.
        quiet();
        ce_main_n = 1'b0;
        pstrb_n = 1'b0; addr_in = {hi_a, 2'd1};
        tick();
        quiet();
        adv_n = 1'b0; tick();                   // now beat 1: 1^1 = 0
        ce_main_n = 1'b1; pstrb_n = 1'b0; adv_n = 1'b0;
        addr_in = 21'h0F0F3;
        tick();
        chk("R3 gated pstrb holds addr", 32'(word_addr), 32'({hi_a, 2'd0}));
        chk("R3 gated pstrb still reading", 32'(drive_en), 32'd1);

        // R4/R8/R9: every write-enable combination on controller starts.
        for (int m = 0; m < 16; m++) begin
            quiet();
            cstrb_n = 1'b0;
            gwr_n = m[3]; bwen_n = m[2]; bw_n = 2'(m);
            addr_in = {19'h01234, 2'(m)};
            tick();
            exp_m = !m[3] ? 2'b11 : (!m[2] ? ~2'(m) : 2'b00);
            chk("R4 cstart addr", 32'(word_addr), 32'({19'h01234, 2'(m)}));
            chk("R8 lane mask", 32'(wr_strb), 32'(exp_m));
            chk("R9 drive vs write", 32'(drive_en), 32'(exp_m == 2'b00));
        end

        // R5/R8: continue edge samples lane writes and advances (start 3).
        quiet();
        adv_n = 1'b0; bwen_n = 1'b0; bw_n = 2'b10;
        tick();
        chk("R5 continue advance", 32'(word_addr), 32'({19'h01234, 2'd2}));
        chk("R8 continue lane write", 32'(wr_strb), 32'd1);
        chk("R9 continue write no drive", 32'(drive_en), 32'd0);

        // R4: both strobes low, processor strobe wins and reads.
        quiet();
        pstrb_n = 1'b0; cstrb_n = 1'b0; gwr_n = 1'b0;
        addr_in = {19'h00777, 2'd2};
        tick();
        chk("R4 pstrb priority addr", 32'(word_addr), 32'({19'h00777, 2'd2}));
        chk("R4 pstrb priority no write", 32'(wr_strb), 32'd0);

        // R10: secondary enable off on processor start deselects.
        quiet();
        pstrb_n = 1'b0; ce_hi = 1'b0;
        tick();
        chk("R10 desel drive", 32'(drive_en), 32'd0);
        quiet();
        gwr_n = 1'b0; adv_n = 1'b0;
        tick();
        chk("R10 desel continue no write", 32'(wr_strb), 32'd0);
        chk("R10 desel continue no drive", 32'(drive_en), 32'd0);
        quiet();
        cstrb_n = 1'b0; ce_lo_n = 1'b1; gwr_n = 1'b0;
        tick();
        chk("R10 cstart low-enable off no write", 32'(wr_strb), 32'd0);
        chk("R10 cstart low-enable off no drive", 32'(drive_en), 32'd0);

        // R4: controller start with main enable off deselects.
        quiet();
        pstrb_n = 1'b0; tick();
        chk("R2 restart drive", 32'(drive_en), 32'd1);
        quiet();
        cstrb_n = 1'b0; ce_main_n = 1'b1;
        tick();
        chk("R4 cstart main off deselects", 32'(drive_en), 32'd0);

        // R7/R11: linear order captured in reset, select flipped after.
        do_reset(1'b0);
        order_sel = 1'b1;
        burst_sweep(1'b0, 19'h4C3B1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 100000);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule